// File: doc/BRIEF.md
# External I/O Bank Strobe Generator

This block produces one strobe line per external I/O bank for a small processor's external I/O cycles. Eight byte-wide control registers, one per bank, are loaded through an internal register port. Each control byte sets the bank's cycle length, the strobe's role, whether writes may strobe, the strobe polarity, an early-ending read strobe, and whether data should use the alternate I/O bus or the memory data bus.

When the core requests an external read or write, the block takes the bank from the top three address bits. It captures that bank's control byte and runs a transaction of fixed length. During the transaction it drives the bank's strobe line and a bus-select flag. All other strobe lines stay at their idle level. The data transfer itself and the pads are outside this block.

Top module: `io_strobe_gen`

## Requirements
- R1: After reset, every control register reads 0x00, `xbusy` and `use_alt_bus` are low, and every `ix` line is high, which is the idle level for active-low.
- R2: A write on the register port to address 0x0080+b (b = 0..7) loads bank b's control byte. The byte reads back on `reg_rdata` while `reg_addr` holds that address. Writes to any other address change no bank, and reads of other addresses return 0x00.
- R3: A request selects bank `xreq_addr[15:13]`. Only that bank's `ix` line may leave its idle level. Every other line sits at its idle level, which is the inverse of its polarity bit.
- R4: A request accepted while idle starts a transaction on the next clock. `xbusy` stays high for exactly 2+W cycles. W comes from control bits 7:6: 00 gives 15, 01 gives 7, 10 gives 3 and 11 gives 1.
- R5: Role bits 5:4 = 00 (chip select): the strobe is asserted in every cycle of the transaction, for reads and for writes, including blocked writes.
- R6: Role 01 (read strobe): the strobe is asserted from cycle 2 to the last cycle on reads, and never on writes.
- R7: Role 10 (write strobe): the strobe is asserted from cycle 2 to the last cycle on permitted writes, and never on reads.
- R8: Role 11 (data strobe): the strobe follows the read timing on reads and the write timing on writes.
- R9: Bit 3 = 0 blocks writes. The write strobe stays idle, but the transaction length does not change.
- R10: Bit 2 = 0 makes the asserted level low. Bit 2 = 1 makes it high.
- R11: Bit 1 = 1 removes the last cycle of a read strobe, so it is asserted from cycle 2 to cycle N-1. The transaction length does not change, and writes are not affected.
- R12: During a transaction, `use_alt_bus` is high exactly when bit 0 of the captured byte is 0 and `alt_bus_en` is high. It is low when idle.
- R13: A request made while busy is dropped and is not queued. The control byte is captured when the request is accepted, so a register write during a transaction does not change that transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr_en | input | 1 | Register port write enable |
| reg_addr | input | 16 | Register port internal I/O address |
| reg_wdata | input | 8 | Register port write data |
| reg_rdata | output | 8 | Control byte at `reg_addr`, or 0x00 |
| xreq_valid | input | 1 | External I/O request |
| xreq_write | input | 1 | 1 = write request, 0 = read request |
| xreq_addr | input | 16 | External I/O address |
| alt_bus_en | input | 1 | Alternate I/O bus enabled |
| xbusy | output | 1 | Transaction in progress |
| ix | output | 8 | Per-bank strobe lines |
| use_alt_bus | output | 1 | Route data on the alternate I/O bus |

## Verification
The bench runs every role against both reads and writes and compares every cycle of each transaction. A design that mixed up the roles would strobe a read-only bank on a write, and one that ignored the write block would pulse the strobe of a blocked bank. The shortened read is checked at the shortest cycle length, where it leaves a single strobe cycle. This exposes a design that trimmed the transaction instead of the strobe, or that also shortened writes. A request and a register rewrite issued in the middle of a busy transaction catch a design that queued the request or read the live register instead of the captured byte. A write to 0x0088, which aliases bank 0 in its low bits, catches an address decode that is too loose.

// File: rtl/iosg_pkg.sv
package iosg_pkg;

    localparam int LEN_W = 5;

    typedef enum logic [1:0] {
        ROLE_CS   = 2'b00,
        ROLE_RD   = 2'b01,
        ROLE_WR   = 2'b10,
        ROLE_DATA = 2'b11
    } ix_role_e;

    // field order matches the control byte, bit 7 first
    typedef struct packed {
        logic [1:0] wait_code;
        ix_role_e   role;
        logic       wr_allow;
        logic       act_high;
        logic       rd_short;
        logic       mem_bus;
    } bank_ctl_t;

    // 2 base cycles plus 15/7/3/1 wait states
    function automatic logic [LEN_W-1:0] xact_len(input logic [1:0] code);
        return LEN_W'(2) + ((LEN_W'(16) >> code) - LEN_W'(1));
    endfunction

endpackage

// File: rtl/iosg_ctl_regs.sv
module iosg_ctl_regs
    import iosg_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE = 16'h0080
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [7:0]                 wdata,
    output logic [7:0]                 rdata,
    output bank_ctl_t [NUM_BANKS-1:0]  ctl_o
);
    localparam int BSEL_W = $clog2(NUM_BANKS);

    bank_ctl_t [NUM_BANKS-1:0] regs_d, regs_q;
    logic [ADDR_W-1:0] offs;
    logic              hit;
    logic [BSEL_W-1:0] idx;

    always_comb begin
        offs   = addr - BASE;
        hit    = (addr >= BASE) && (offs < ADDR_W'(NUM_BANKS));
        idx    = offs[BSEL_W-1:0];
        regs_d = regs_q;
        if (wr_en && hit)
            regs_d[idx] = bank_ctl_t'(wdata);
        rdata = hit ? 8'(regs_q[idx]) : 8'h00;
    end

    always_ff @(posedge clk) begin
        if (rst) regs_q <= '0;
        else     regs_q <= regs_d;
    end

    assign ctl_o = regs_q;

    // R2
    reg_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && hit) |=> (8'(regs_q[$past(idx)]) == $past(wdata)));

    // R2
    reg_miss_chk: assert property (@(posedge clk) disable iff (rst)
        (!(wr_en && hit)) |=> $stable(regs_q));

endmodule

// File: rtl/iosg_xact_seq.sv
module iosg_xact_seq
    import iosg_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    localparam int BSEL_W = $clog2(NUM_BANKS)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic [BSEL_W-1:0]         req_bank,
    input  bank_ctl_t [NUM_BANKS-1:0] ctl_all,
    output logic                      busy,
    output logic [LEN_W-1:0]          cyc,
    output logic [LEN_W-1:0]          len,
    output logic                      write,
    output logic [BSEL_W-1:0]         bank,
    output bank_ctl_t                 ctl
);
    typedef struct packed {
        logic              active;
        logic [LEN_W-1:0]  cyc;
        logic [LEN_W-1:0]  len;
        logic              write;
        logic [BSEL_W-1:0] bank;
        bank_ctl_t         ctl;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.active) begin
            if (req_valid) begin
                st_d.active = 1'b1;
                st_d.cyc    = LEN_W'(1);
                st_d.len    = xact_len(ctl_all[req_bank].wait_code);
                st_d.write  = req_write;
                st_d.bank   = req_bank;
                st_d.ctl    = ctl_all[req_bank];
            end
        end else if (st_q.cyc == st_q.len) begin
            st_d.active = 1'b0;
        end else begin
            st_d.cyc = st_q.cyc + LEN_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign busy  = st_q.active;
    assign cyc   = st_q.cyc;
    assign len   = st_q.len;
    assign write = st_q.write;
    assign bank  = st_q.bank;
    assign ctl   = st_q.ctl;

    // R4
    cyc_range_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.active |-> (st_q.cyc >= LEN_W'(1) && st_q.cyc <= st_q.len));

    // R4
    len_legal_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.active |-> (st_q.len inside {LEN_W'(3), LEN_W'(5), LEN_W'(9), LEN_W'(17)}));

    // R13
    held_ctl_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.active && st_q.cyc != st_q.len) |=>
            (st_q.active && $stable(st_q.ctl) && $stable(st_q.bank) && $stable(st_q.write)));

endmodule

// File: rtl/iosg_strobe_shape.sv
module iosg_strobe_shape
    import iosg_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    localparam int BSEL_W = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 busy,
    input  logic [LEN_W-1:0]     cyc,
    input  logic [LEN_W-1:0]     len,
    input  logic                 write,
    input  logic [BSEL_W-1:0]    bank,
    input  bank_ctl_t            ctl,
    input  logic [NUM_BANKS-1:0] idle_lvl,
    input  logic                 alt_bus_en,
    output logic [NUM_BANKS-1:0] ix_o,
    output logic                 use_alt
);
    logic strobe_ph, rd_ph, wr_ph, act;

    always_comb begin
        strobe_ph = busy && (cyc >= LEN_W'(2));
        rd_ph     = strobe_ph && !(ctl.rd_short && cyc == len);
        wr_ph     = strobe_ph && ctl.wr_allow;
        unique case (ctl.role)
            ROLE_CS:   act = busy;
            ROLE_RD:   act = !write && rd_ph;
            ROLE_WR:   act = write && wr_ph;
            ROLE_DATA: act = write ? wr_ph : rd_ph;
            default:   act = 1'b0;
        endcase
        use_alt = busy && !ctl.mem_bus && alt_bus_en;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign ix_o[b] = (busy && bank == BSEL_W'(b))
                         ? (ctl.act_high ? act : ~act)
                         : idle_lvl[b];
    end

    // R3
    idle_ix_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (ix_o == idle_lvl));

    // R9
    no_blocked_write_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && write && !ctl.wr_allow && ctl.role != ROLE_CS) |->
            (ix_o[bank] == ~ctl.act_high));

    // R11
    short_read_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !write && ctl.rd_short && cyc == len && ctl.role != ROLE_CS) |->
            (ix_o[bank] == ~ctl.act_high));

    // R12
    alt_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !use_alt);

endmodule

// File: rtl/io_strobe_gen.sv
module io_strobe_gen
    import iosg_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] REG_BASE = 16'h0080
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr_en,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [7:0]           reg_wdata,
    output logic [7:0]           reg_rdata,
    input  logic                 xreq_valid,
    input  logic                 xreq_write,
    input  logic [ADDR_W-1:0]    xreq_addr,
    input  logic                 alt_bus_en,
    output logic                 xbusy,
    output logic [NUM_BANKS-1:0] ix,
    output logic                 use_alt_bus
);
    localparam int BSEL_W = $clog2(NUM_BANKS);

    bank_ctl_t [NUM_BANKS-1:0] ctl_all;
    logic [NUM_BANKS-1:0]      idle_lvl;
    logic [LEN_W-1:0]          cyc, len;
    logic                      cur_write;
    logic [BSEL_W-1:0]         cur_bank;
    bank_ctl_t                 cur_ctl;

    iosg_ctl_regs #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .BASE(REG_BASE)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (reg_wr_en),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .ctl_o (ctl_all)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_idle
        assign idle_lvl[b] = ~ctl_all[b].act_high;
    end

    iosg_xact_seq #(.NUM_BANKS(NUM_BANKS)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (xreq_valid),
        .req_write (xreq_write),
        .req_bank  (xreq_addr[ADDR_W-1 -: BSEL_W]),
        .ctl_all   (ctl_all),
        .busy      (xbusy),
        .cyc       (cyc),
        .len       (len),
        .write     (cur_write),
        .bank      (cur_bank),
        .ctl       (cur_ctl)
    );

    iosg_strobe_shape #(.NUM_BANKS(NUM_BANKS)) u_shape (
        .clk        (clk),
        .rst        (rst),
        .busy       (xbusy),
        .cyc        (cyc),
        .len        (len),
        .write      (cur_write),
        .bank       (cur_bank),
        .ctl        (cur_ctl),
        .idle_lvl   (idle_lvl),
        .alt_bus_en (alt_bus_en),
        .ix_o       (ix),
        .use_alt    (use_alt_bus)
    );

endmodule

// File: tb/test_io_strobe_gen.sv
module test_io_strobe_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [15:0] reg_addr = 16'h0;
    logic [7:0]  reg_wdata = 8'h0;
    logic [7:0]  reg_rdata;
    logic        xreq_valid = 1'b0;
    logic        xreq_write = 1'b0;
    logic [15:0] xreq_addr = 16'h0;
    logic        alt_bus_en = 1'b0;
    logic        xbusy;
    logic [7:0]  ix;
    logic        use_alt_bus;

    int tests = 0;
    int fails = 0;
    logic [7:0] cfg_sh [8];

    always #2 clk = ~clk;

    io_strobe_gen i_io_strobe_gen (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xreq_valid(xreq_valid),
        .xreq_write(xreq_write), .xreq_addr(xreq_addr), .alt_bus_en(alt_bus_en),
        .xbusy(xbusy), .ix(ix), .use_alt_bus(use_alt_bus)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] idle_vec();
        logic [7:0] v;
        for (int b = 0; b < 8; b++) v[b] = ~cfg_sh[b][2];
        return v;
    endfunction

    function automatic bit exp_act(input logic [7:0] c, input bit wr, input int k, input int n);
        bit st, rd;
        st = (k >= 2);
        rd = st && !(c[1] && k == n);
        case (c[5:4])
            2'b00: return 1'b1;
            2'b01: return !wr && rd;
            2'b10: return wr && c[3] && st;
            default: return wr ? (c[3] && st) : rd;
        endcase
    endfunction

    task automatic reg_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
        if (a >= 16'h0080 && a <= 16'h0087) cfg_sh[a[2:0]] = d;
    endtask

    task automatic reg_check(input logic [15:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(reg_rdata == exp, req, "reg_rdata", 16'(reg_rdata), 16'(exp));
    endtask

    // one transaction, checked cycle by cycle; optional mid-transaction disturbances
    task automatic run_xact(input int bank, input bit wr, input bit alt, input string req,
                            input bit mid_dist);
        logic [7:0] c;
        int n, bad_k;
        logic [7:0] ev, got_ix;
        bit eb, ea, got_b, got_a, ok;
        c = cfg_sh[bank];
        n = 2 + ((16 >> c[7:6]) - 1);
        ok = 1'b1; bad_k = 0; ev = '0; got_ix = '0; eb = 0; ea = 0; got_b = 0; got_a = 0;
        @(negedge clk);
        xreq_valid = 1'b1; xreq_write = wr; xreq_addr = {3'(bank), 13'h0155};
        alt_bus_en = alt;
        @(negedge clk);
        xreq_valid = 1'b0;
        for (int k = 1; k <= n + 1; k++) begin
            if (k > 1) @(negedge clk);
            if (mid_dist && k == 2) begin
                xreq_valid = 1'b1; xreq_write = 1'b0; xreq_addr = {3'd3, 13'h0};
                reg_wr_en = 1'b1; reg_addr = 16'h0080 + 16'(bank); reg_wdata = c ^ 8'h04;
            end
            if (mid_dist && k == 3) begin
                xreq_valid = 1'b0; reg_wr_en = 1'b0;
                cfg_sh[bank] = c ^ 8'h04;
            end
            ev = idle_vec();
            if (k <= n) begin
                ev[bank] = c[2] ? exp_act(c, wr, k, n) : ~exp_act(c, wr, k, n);
                eb = 1'b1;
                ea = alt && !c[0];
            end else begin
                if (mid_dist) ev[bank] = ~cfg_sh[bank][2];
                eb = 1'b0; ea = 1'b0;
            end
            if (ok && (ix !== ev || xbusy !== eb || use_alt_bus !== ea)) begin
                ok = 1'b0; bad_k = k; got_ix = ix; got_b = xbusy; got_a = use_alt_bus;
            end
        end
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s bank%0d wr=%0d cycle %0d: actual ix=%h busy=%0d alt=%0d expected ix=%h busy=%0d alt=%0d",
                     req, bank, wr, bad_k, got_ix, got_b, got_a, ev, eb, ea);
        end
    endtask

    task automatic t_reset();
        check(reg_rdata == 8'h00, "R1", "reg_rdata", 16'(reg_rdata), 16'h0);
        check(ix == 8'hFF, "R1", "ix idle", 16'(ix), 16'hFF);
        check(xbusy == 1'b0 && use_alt_bus == 1'b0, "R1", "busy/alt", {xbusy, use_alt_bus}, 16'h0);
        for (int b = 0; b < 8; b++) reg_check(16'h0080 + 16'(b), 8'h00, "R1");
        // default byte: 17-cycle chip select, active low
        run_xact(7, 1'b0, 1'b1, "R1_R4_R5 default", 1'b0);
    endtask

    task automatic t_regs();
        logic [7:0] vals [8];
        vals = '{8'hC0, 8'h90, 8'h6D, 8'hFA, 8'h16, 8'hB0, 8'hE0, 8'h0D};
        for (int b = 0; b < 8; b++) reg_write(16'h0080 + 16'(b), vals[b]);
        for (int b = 0; b < 8; b++) reg_check(16'h0080 + 16'(b), vals[b], "R2");
        reg_write(16'h0088, 8'h33);
        reg_write(16'h007F, 8'h44);
        reg_write(16'h1080, 8'h55);
        reg_check(16'h0080, 8'hC0, "R2 alias");
        reg_check(16'h0087, 8'h0D, "R2 alias");
        reg_check(16'h0088, 8'h00, "R2 outside");
        check(ix == idle_vec(), "R10", "idle levels", 16'(ix), 16'(idle_vec()));
    endtask

    task automatic t_roles();
        run_xact(0, 1'b0, 1'b0, "R5 cs read", 1'b0);
        run_xact(0, 1'b1, 1'b0, "R5_R9 cs blocked write", 1'b0);
        run_xact(1, 1'b0, 1'b0, "R6 read strobe read", 1'b0);
        run_xact(1, 1'b1, 1'b0, "R6 read strobe write", 1'b0);
        run_xact(2, 1'b1, 1'b1, "R7_R10_R12 write strobe write", 1'b0);
        run_xact(2, 1'b0, 1'b1, "R7 write strobe read", 1'b0);
        run_xact(3, 1'b0, 1'b1, "R8_R11 data strobe short read", 1'b0);
        run_xact(3, 1'b1, 1'b0, "R8_R11 data strobe write", 1'b0);
        run_xact(4, 1'b0, 1'b0, "R11_R10 short read high", 1'b0);
        run_xact(4, 1'b1, 1'b0, "R6 read role on write", 1'b0);
        run_xact(5, 1'b0, 1'b0, "R8 data read", 1'b0);
        run_xact(5, 1'b1, 1'b0, "R9 data blocked write", 1'b0);
        run_xact(6, 1'b1, 1'b0, "R9 wr blocked write", 1'b0);
        run_xact(7, 1'b0, 1'b1, "R12 mem bus forced", 1'b0);
    endtask

    task automatic t_alt_bus();
        run_xact(1, 1'b0, 1'b1, "R12 alt enabled", 1'b0);
        run_xact(1, 1'b0, 1'b0, "R12 alt disabled", 1'b0);
    endtask

    task automatic t_busy_ignore();
        run_xact(1, 1'b0, 1'b0, "R13 mid request and rewrite", 1'b1);
        @(negedge clk);
        check(xbusy == 1'b0, "R13", "no queued request", 16'(xbusy), 16'h0);
        reg_check(16'h0081, 8'h94, "R13 rewrite landed");
        run_xact(1, 1'b0, 1'b0, "R13_R10 new polarity used", 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_regs();
        t_roles();
        t_alt_bus();
        t_busy_ignore();
        repeat (2) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int b = 0; b < 8; b++) cfg_sh[b] = 8'h00;
        repeat (20000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule